// File: doc/BRIEF.md
# Timer Compare/Capture Channel

This block is one compare/capture channel of a general-purpose timer. It watches a free-running counter value supplied from outside, holds one general register, and owns one bidirectional pin. A 4-bit mode field selects the channel's behaviour. In compare modes the channel drives the pin and updates it whenever the counter equals the general register. In capture modes the channel latches the counter into the general register on a chosen pin edge, or on a count event from a neighbouring channel. Every compare or capture event raises a sticky flag.

A write to the mode field can also set the pin's starting level, so a waveform begins from a known state. A buffer-mode input suppresses all compare and capture events. The pin input passes through a two-stage synchroniser before any edge is detected.

Top module: `tmr_cc_chan`

## Requirements
- R1: After reset `pinOut` is 0, `pinOe` is 1, `flag` is 0, `grRdata` is 0 and the mode is 0000.
- R2: Writing mode 0001, 0010 or 0011 sets `pinOut` to 0 on the next clock. Writing mode 0101, 0110 or 0111 sets it to 1.
- R3: Modes 0000 and 0100 leave `pinOut` unchanged, both when written and on a compare match, but a match still sets `flag`.
- R4: A compare match is a cycle in which `cntEn` is 1, the mode has bit 3 clear and `cntVal` equals the general register. On the next clock the pin goes low when mode bits [1:0] are 01, goes high when they are 10, toggles when they are 11, and `flag` is set.
- R5: When `cntEn` is 0, or `cntVal` differs from the general register, no match occurs: the pin and the flag are unchanged.
- R6: In modes with bit 3 set, `pinOe` is 0 and `pinOut` keeps its last value.
- R7: Mode 1000 captures on a rising pin edge, 1001 on a falling edge, and 1010 or 1011 on both edges. The capture loads `cntVal` into the general register and sets `flag` on the third clock after the pin changes. Edges of the wrong polarity are ignored.
- R8: Modes 11xx capture when `nbrCntEvt` is 1 (next clock) and ignore the pin.
- R9: While `bufMode` is 1, no compare or capture event occurs: the flag, the pin and the register do not change. A mode write still loads the initial level.
- R10: `flag` stays set until a cycle with `flagClr` at 1 clears it. A same-cycle event wins over the clear.
- R11: `grWe` writes `grWdata` to the general register. A same-cycle capture wins.
- R12: A mode write that sets an initial level wins over a compare match in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Mode field write strobe |
| cfgMode | input | 4 | Mode value to write |
| grWe | input | 1 | General register write strobe |
| grWdata | input | 16 | General register write data |
| grRdata | output | 16 | General register contents |
| cntVal | input | 16 | Free-running counter value |
| cntEn | input | 1 | Counter enable qualifying compare |
| nbrCntEvt | input | 1 | Neighbouring channel count-up/count-down event |
| bufMode | input | 1 | Suppresses compare and capture events |
| pinIn | input | 1 | Asynchronous pin input |
| flagClr | input | 1 | Write-one clear of the flag |
| pinOut | output | 1 | Pin output level |
| pinOe | output | 1 | Pin output enable |
| flag | output | 1 | Sticky match/capture flag |

## Verification
The hardest situations to reach are the same-cycle collisions: a clear meeting a set, a mode write meeting a match, and a register write meeting a capture. Reaching them needs the counter, the register and the strobes lined up on one exact clock. The bench drives every input at the falling edge, so it can place a match, a clear or a neighbour event in exactly the cycle of a write. Capture timing through the synchroniser is pinned down by checking the flag one cycle before the capture and again at the capture cycle.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } pinAct_e;

  typedef struct packed {
    logic    loadInit;
    logic    initLvl;
    pinAct_e act;
    logic    capture;
    logic    setFlag;
  } strobe_t;
endpackage

// File: rtl/tcc_ctrl.sv
module tcc_ctrl #(
  parameter int MODE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [MODE_W-1:0] cfgMode,
  input  logic              cntEn,
  input  logic              eq,
  input  logic              bufMode,
  input  logic              pinIn,
  input  logic              nbrEvt,
  output tcc_pkg::strobe_t  stb,
  output logic              oe
);
  import tcc_pkg::*;

  localparam int SYNC_TOP = SYNC_STAGES - 1;

  logic [MODE_W-1:0]    modeQ;
  logic [SYNC_STAGES:0] syncQ;  // [SYNC_TOP] synchronised, [SYNC_STAGES] previous sample
  logic rise, fall, capSel, isCapMode, matchEvt, capEvt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0;
      syncQ <= '0;
    end else begin
      if (cfgWe) modeQ <= cfgMode;
      syncQ <= {syncQ[SYNC_STAGES-1:0], pinIn};
    end
  end

  assign rise      = syncQ[SYNC_TOP] & ~syncQ[SYNC_STAGES];
  assign fall      = ~syncQ[SYNC_TOP] & syncQ[SYNC_STAGES];
  assign isCapMode = modeQ[3];

  always_comb begin
    unique case (modeQ[2:1])
      2'b00:   capSel = modeQ[0] ? fall : rise;
      2'b01:   capSel = rise | fall;
      default: capSel = nbrEvt;
    endcase
  end

  assign matchEvt = ~isCapMode & cntEn & eq & ~bufMode;
  assign capEvt   = isCapMode & capSel & ~bufMode;

  always_comb begin
    stb          = '0;
    stb.loadInit = cfgWe & ~cfgMode[3] & (cfgMode[1:0] != 2'b00);
    stb.initLvl  = cfgMode[2];
    stb.act      = matchEvt ? pinAct_e'(modeQ[1:0]) : ACT_NONE;
    stb.capture  = capEvt;
    stb.setFlag  = matchEvt | capEvt;
  end

  assign oe = ~isCapMode;
endmodule

// File: rtl/tcc_dpath.sv
module tcc_dpath #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tcc_pkg::strobe_t stb,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             grWe,
  input  logic [CNT_W-1:0] grWdata,
  input  logic             flagClr,
  output logic             eq,
  output logic [CNT_W-1:0] grQ,
  output logic             pinQ,
  output logic             flagQ
);
  import tcc_pkg::*;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grQ   <= '0;
      pinQ  <= 1'b0;
      flagQ <= 1'b0;
    end else begin
      if (stb.capture)   grQ <= cntVal;
      else if (grWe)     grQ <= grWdata;

      if (stb.loadInit) pinQ <= stb.initLvl;
      else begin
        unique case (stb.act)
          ACT_LOW:    pinQ <= 1'b0;
          ACT_HIGH:   pinQ <= 1'b1;
          ACT_TOGGLE: pinQ <= ~pinQ;
          default:    pinQ <= pinQ;
        endcase
      end

      if (stb.setFlag)   flagQ <= 1'b1;
      else if (flagClr)  flagQ <= 1'b0;
    end
  end

  assign eq = (cntVal == grQ);
endmodule

// File: rtl/tmr_cc_chan.sv
module tmr_cc_chan #(
  parameter int CNT_W       = 16,
  parameter int MODE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [MODE_W-1:0] cfgMode,
  input  logic              grWe,
  input  logic [CNT_W-1:0]  grWdata,
  output logic [CNT_W-1:0]  grRdata,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic              cntEn,
  input  logic              nbrCntEvt,
  input  logic              bufMode,
  input  logic              pinIn,
  input  logic              flagClr,
  output logic              pinOut,
  output logic              pinOe,
  output logic              flag
);
  tcc_pkg::strobe_t stb;
  logic eq;

  tcc_ctrl #(.MODE_W(MODE_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgMode(cfgMode), .cntEn(cntEn),
    .eq(eq), .bufMode(bufMode), .pinIn(pinIn), .nbrEvt(nbrCntEvt),
    .stb(stb), .oe(pinOe)
  );

  tcc_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .cntVal(cntVal), .grWe(grWe),
    .grWdata(grWdata), .flagClr(flagClr), .eq(eq), .grQ(grRdata),
    .pinQ(pinOut), .flagQ(flag)
  );
endmodule

// File: rtl/tcc_chk.sv
module tcc_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWe,
  input logic [3:0]       cfgMode,
  input logic             cntEn,
  input logic [CNT_W-1:0] cntVal,
  input logic             bufMode,
  input logic [CNT_W-1:0] grRdata,
  input logic             flagClr,
  input logic             pinOut,
  input logic             pinOe,
  input logic             flag
);
  logic [3:0] curMode;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curMode <= '0;
    else if (cfgWe) curMode <= cfgMode;
  end

  p_reset_state_r1: assert property (@(posedge clk)
    $rose(rstN) |-> (!pinOut && !flag && pinOe));

  p_init_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgMode[3:2] == 2'b00 && cfgMode[1:0] != 2'b00) |=> !pinOut);

  p_init_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgMode[3:2] == 2'b01 && cfgMode[1:0] != 2'b00) |=> pinOut);

  p_retain_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgWe && (curMode[3] || curMode[1:0] == 2'b00)) |=> $stable(pinOut));

  p_toggle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgWe && curMode == 4'b0011 && cntEn && !bufMode && cntVal == grRdata)
      |=> (pinOut != $past(pinOut)));

  p_no_match_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!cntEn && !curMode[3] && !flag) |=> !flag);

  p_oe_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgMode[3]) |=> !pinOe);

  p_buf_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (bufMode && !flag) |=> !flag);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && bufMode) |=> !flag);
endmodule

bind tmr_cc_chan tcc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgMode(cfgMode), .cntEn(cntEn),
  .cntVal(cntVal), .bufMode(bufMode), .grRdata(grRdata), .flagClr(flagClr),
  .pinOut(pinOut), .pinOe(pinOe), .flag(flag)
);

// File: tb/sim_tmr_cc_chan.sv
module sim_tmr_cc_chan;
  logic        clk = 1'b0;
  logic        rstN, cfgWe, grWe, cntEn, nbrCntEvt, bufMode, pinIn, flagClr;
  logic [3:0]  cfgMode;
  logic [15:0] grWdata, cntVal, grRdata;
  logic        pinOut, pinOe, flag;
  int nChk = 0, nFail = 0;

  always #2 clk = ~clk;

  tmr_cc_chan u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgMode(cfgMode), .grWe(grWe),
    .grWdata(grWdata), .grRdata(grRdata), .cntVal(cntVal), .cntEn(cntEn),
    .nbrCntEvt(nbrCntEvt), .bufMode(bufMode), .pinIn(pinIn), .flagClr(flagClr),
    .pinOut(pinOut), .pinOe(pinOe), .flag(flag)
  );

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wrMode(logic [3:0] m);
    cfgWe = 1'b1; cfgMode = m; cyc(1); cfgWe = 1'b0;
  endtask

  task automatic wrGr(logic [15:0] v);
    grWe = 1'b1; grWdata = v; cyc(1); grWe = 1'b0;
  endtask

  task automatic clrFlag();
    flagClr = 1'b1; cyc(1); flagClr = 1'b0;
  endtask

  task automatic matchOnce();
    cntVal = 16'd100; cntEn = 1'b1; cyc(1); cntEn = 1'b0; cntVal = 16'd0;
  endtask

  task automatic t_reset();
    chk("R1", "pinOut", pinOut, 0);
    chk("R1", "pinOe", pinOe, 1);
    chk("R1", "flag", flag, 0);
    chk("R1", "grRdata", grRdata, 0);
  endtask

  task automatic t_init();
    wrMode(4'b0101); chk("R2", "init 0101", pinOut, 1);
    wrMode(4'b0001); chk("R2", "init 0001", pinOut, 0);
    wrMode(4'b0110); chk("R2", "init 0110", pinOut, 1);
    wrMode(4'b0010); chk("R2", "init 0010", pinOut, 0);
    wrMode(4'b0111); chk("R2", "init 0111", pinOut, 1);
    wrMode(4'b0011); chk("R2", "init 0011", pinOut, 0);
  endtask

  task automatic t_match();
    wrGr(16'd100);
    wrMode(4'b0101); matchOnce();
    chk("R4", "drive low", pinOut, 0);
    chk("R4", "flag on match", flag, 1);
    cyc(2); chk("R10", "flag sticky", flag, 1);
    clrFlag(); chk("R10", "flag cleared", flag, 0);
    wrMode(4'b0010); matchOnce(); chk("R4", "drive high", pinOut, 1);
    wrMode(4'b0011); matchOnce(); chk("R4", "toggle 1", pinOut, 1);
    matchOnce(); chk("R4", "toggle 2", pinOut, 0);
    clrFlag();
  endtask

  task automatic t_enable();
    wrMode(4'b0101);
    cntVal = 16'd100; cntEn = 1'b0; cyc(2);
    chk("R5", "pin with cntEn low", pinOut, 1);
    chk("R5", "flag with cntEn low", flag, 0);
    cntVal = 16'd99; cntEn = 1'b1; cyc(2); cntEn = 1'b0;
    chk("R5", "pin unequal", pinOut, 1);
    chk("R5", "flag unequal", flag, 0);
  endtask

  task automatic t_retain();
    wrMode(4'b0111);
    wrMode(4'b0000); chk("R3", "0000 write keeps pin", pinOut, 1);
    matchOnce(); chk("R3", "0000 match keeps pin", pinOut, 1);
    chk("R3", "0000 match flag", flag, 1);
    clrFlag();
    wrMode(4'b0100); matchOnce(); chk("R3", "0100 match keeps pin", pinOut, 1);
    chk("R3", "0100 match flag", flag, 1);
    clrFlag();
  endtask

  task automatic t_capture();
    wrMode(4'b0111);
    wrMode(4'b1000);
    chk("R6", "oe in capture", pinOe, 0);
    chk("R6", "pin retained", pinOut, 1);
    cntVal = 16'h1234; pinIn = 1'b1; cyc(2);
    chk("R7", "no flag before sync", flag, 0);
    cyc(1);
    chk("R7", "rising capture value", grRdata, 16'h1234);
    chk("R7", "rising capture flag", flag, 1);
    clrFlag();
    cntVal = 16'h2222; pinIn = 1'b0; cyc(4);
    chk("R7", "falling ignored in 1000", grRdata, 16'h1234);
    chk("R7", "no flag on falling", flag, 0);
    wrMode(4'b1001);
    cntVal = 16'h3333; pinIn = 1'b1; cyc(4);
    chk("R7", "rising ignored in 1001", grRdata, 16'h1234);
    pinIn = 1'b0; cyc(3);
    chk("R7", "falling capture", grRdata, 16'h3333);
    chk("R7", "falling flag", flag, 1);
    clrFlag();
    wrMode(4'b1010);
    cntVal = 16'h4444; pinIn = 1'b1; cyc(3);
    chk("R7", "both: rising", grRdata, 16'h4444);
    clrFlag();
    cntVal = 16'h5555; pinIn = 1'b0; cyc(3);
    chk("R7", "both: falling", grRdata, 16'h5555);
    clrFlag();
    chk("R6", "pin still retained", pinOut, 1);
  endtask

  task automatic t_nbr();
    wrMode(4'b1100);
    cntVal = 16'h0666; pinIn = 1'b1; cyc(4); pinIn = 1'b0; cyc(4);
    chk("R8", "pin ignored value", grRdata, 16'h5555);
    chk("R8", "pin ignored flag", flag, 0);
    cntVal = 16'h0777; nbrCntEvt = 1'b1; cyc(1); nbrCntEvt = 1'b0;
    chk("R8", "neighbour capture", grRdata, 16'h0777);
    chk("R8", "neighbour flag", flag, 1);
    clrFlag();
  endtask

  task automatic t_buf();
    bufMode = 1'b1;
    cntVal = 16'h0888; nbrCntEvt = 1'b1; cyc(1); nbrCntEvt = 1'b0;
    chk("R9", "no capture in buf", grRdata, 16'h0777);
    chk("R9", "no capture flag", flag, 0);
    wrMode(4'b0101); chk("R9", "init still loads", pinOut, 1);
    wrGr(16'd100); matchOnce();
    chk("R9", "no match pin", pinOut, 1);
    chk("R9", "no match flag", flag, 0);
    bufMode = 1'b0;
  endtask

  task automatic t_prio();
    flagClr = 1'b1; matchOnce(); flagClr = 1'b0;
    chk("R10", "set beats clear", flag, 1);
    chk("R4", "match with clear", pinOut, 0);
    clrFlag();
    wrMode(4'b0010);
    cfgWe = 1'b1; cfgMode = 4'b0001; cntVal = 16'd100; cntEn = 1'b1; cyc(1);
    cfgWe = 1'b0; cntEn = 1'b0; cntVal = 16'd0;
    chk("R12", "write beats match", pinOut, 0);
    clrFlag();
    wrMode(4'b1100);
    grWe = 1'b1; grWdata = 16'hAAAA; cntVal = 16'h0BBB; nbrCntEvt = 1'b1; cyc(1);
    grWe = 1'b0; nbrCntEvt = 1'b0;
    chk("R11", "capture beats write", grRdata, 16'h0BBB);
    clrFlag();
    wrGr(16'hAAAA); chk("R11", "plain write", grRdata, 16'hAAAA);
  endtask

  initial begin
    rstN = 1'b0; cfgWe = 1'b0; grWe = 1'b0; cntEn = 1'b0; nbrCntEvt = 1'b0;
    bufMode = 1'b0; pinIn = 1'b0; flagClr = 1'b0; cfgMode = '0;
    grWdata = '0; cntVal = '0;
    cyc(3); rstN = 1'b1; cyc(1);
    t_reset();
    t_init();
    t_match();
    t_enable();
    t_retain();
    t_capture();
    t_nbr();
    t_buf();
    t_prio();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #400000;
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule